// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block is the purely combinational control unit of a single-cycle 32-bit load/store processor. Each cycle it looks at the 6-bit major opcode (instruction bits 31:26), a flag saying whether the first source register reads as zero, and an interrupt request. From these it produces every steering signal the datapath needs. The register numbers and the 16-bit literal go straight from the instruction to the datapath and do not pass through this block.

The opcode is first sorted into one of nine instruction classes: register operate, constant operate, load, store, PC-relative load, jump, branch-if-zero, branch-if-nonzero, and illegal. A flow stage then chooses the next-PC source. The branch condition is resolved there. A pending interrupt or an illegal opcode turns the cycle into a forced procedure call: PC+4 goes into the exception register (register 30), the PC takes a vector, and the instruction's own effects are dropped.

Multiply and divide are optional function codes. Two parameters, `HAS_MUL` and `HAS_DIV`, decide whether each one decodes as legal or traps.

Top module: `ctl_decode`

## Requirements
- R1: Opcodes 0x20 to 0x2F with a legal function code in opcode[3:0] decode as register operate. The outputs are alu_fn = opcode[3:0], b_lit = 0, wd_sel = 1 (ALU), wa_xp = 0, reg_we = 1, mem_re = 0, mem_we = 0 and pc_sel = 0 (PC+4).
- R2: Opcodes 0x30 to 0x3F with a legal function code decode exactly as R1, except that b_lit = 1, so the sign-extended literal replaces the second register.
- R3: Function codes 0 ADD, 1 SUB, 4 CMPEQ, 5 CMPLT, 6 CMPLE, 8 AND, 9 OR, 10 XOR, 12 SHL, 13 SHR and 14 SRA are always legal. Codes 7, 11 and 15 are always illegal. Code 2 (MUL) is legal only when HAS_MUL is nonzero, and code 3 (DIV) only when HAS_DIV is nonzero.
- R4: Load, opcode 0x18, gives alu_fn = 0 (ADD), b_lit = 1, mem_re = 1, wd_sel = 2 (memory), wa_xp = 0, reg_we = 1, mem_we = 0 and pc_sel = 0.
- R5: Store, opcode 0x19, gives alu_fn = 0, b_lit = 1, rc_to_rb = 1 (the Rc field drives the second read port), mem_we = 1, mem_re = 0, reg_we = 0 and pc_sel = 0.
- R6: PC-relative load, opcode 0x1F, gives pc_rel = 1 (memory address PC+4+4*sext(C)), mem_re = 1, wd_sel = 2, wa_xp = 0, reg_we = 1, mem_we = 0 and pc_sel = 0.
- R7: Jump, opcode 0x1B, gives pc_sel = 2 (register Ra), wd_sel = 0 (PC+4), wa_xp = 0, reg_we = 1 and no memory access.
- R8: Branch-if-zero (0x1D) and branch-if-nonzero (0x1E) write PC+4 to Rc (wd_sel = 0, reg_we = 1). pc_sel is 1 (branch target) when the condition holds, meaning ra_zero = 1 for 0x1D and ra_zero = 0 for 0x1E. Otherwise pc_sel is 0.
- R9: Every opcode not covered by R1 to R8 is illegal and gives pc_sel = 3 (illegal-op vector), wa_xp = 1, wd_sel = 0, reg_we = 1, mem_we = 0 and mem_re = 0.
- R10: When irq = 1, the outputs are the same as R9 except pc_sel = 4 (interrupt vector), whatever the opcode and ra_zero are.
- R11: Fields a class does not use read as zero. alu_fn is 0 outside R1 and R2. b_lit is 1 only for R2, R4 and R5. rc_to_rb is 1 only for R5. pc_rel is 1 only for R6. All four are 0 under R9 and R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 6 | Instruction bits 31:26 |
| ra_zero | input | 1 | Register Ra currently reads as zero |
| irq | input | 1 | Asynchronous interrupt request |
| alu_fn | output | 4 | ALU function code |
| b_lit | output | 1 | Second ALU operand is the sign-extended literal |
| rc_to_rb | output | 1 | Second read port addressed by the Rc field |
| pc_rel | output | 1 | Memory address from the PC-relative adder |
| wd_sel | output | 2 | Write data: 0 PC+4, 1 ALU, 2 memory |
| wa_xp | output | 1 | Write address is register 30 instead of Rc |
| reg_we | output | 1 | Register file write enable |
| mem_re | output | 1 | Data memory read enable |
| mem_we | output | 1 | Data memory write enable |
| pc_sel | output | 3 | Next PC: 0 PC+4, 1 branch, 2 Ra, 3 illegal vector, 4 interrupt vector |

## Verification
The bench builds the decoder with HAS_MUL = 1 and HAS_DIV = 0. One instance therefore covers both branches of R3: multiply decodes as a legal operate in both operand classes, and divide takes the illegal-op trap. Every one of the 64 opcodes is swept with all four combinations of ra_zero and irq, so both branch polarities and interrupt precedence over illegal opcodes are reached. A long run of seeded random inputs then repeats the comparison against the bench's own model.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    typedef enum logic [3:0] {
        CL_OP  = 4'd0,
        CL_OPC = 4'd1,
        CL_LD  = 4'd2,
        CL_ST  = 4'd3,
        CL_LDR = 4'd4,
        CL_JMP = 4'd5,
        CL_BEQ = 4'd6,
        CL_BNE = 4'd7,
        CL_ILL = 4'd8
    } iclass_e;

    typedef enum logic [3:0] {
        FN_ADD   = 4'd0,
        FN_SUB   = 4'd1,
        FN_MUL   = 4'd2,
        FN_DIV   = 4'd3,
        FN_CMPEQ = 4'd4,
        FN_CMPLT = 4'd5,
        FN_CMPLE = 4'd6,
        FN_AND   = 4'd8,
        FN_OR    = 4'd9,
        FN_XOR   = 4'd10,
        FN_SHL   = 4'd12,
        FN_SHR   = 4'd13,
        FN_SRA   = 4'd14
    } alufn_e;

    typedef enum logic [1:0] {
        WD_PC4 = 2'd0,
        WD_ALU = 2'd1,
        WD_MEM = 2'd2
    } wdsel_e;

    typedef enum logic [2:0] {
        PC_SEQ   = 3'd0,
        PC_BR    = 3'd1,
        PC_REG   = 3'd2,
        PC_ILLOP = 3'd3,
        PC_IRQ   = 3'd4
    } pcsel_e;

    localparam int OPW = 6;
    localparam int FNW = 4;

    localparam logic [OPW-1:0] OPC_LD  = 6'h18;
    localparam logic [OPW-1:0] OPC_ST  = 6'h19;
    localparam logic [OPW-1:0] OPC_JMP = 6'h1B;
    localparam logic [OPW-1:0] OPC_BEQ = 6'h1D;
    localparam logic [OPW-1:0] OPC_BNE = 6'h1E;
    localparam logic [OPW-1:0] OPC_LDR = 6'h1F;

endpackage

// File: rtl/ctl_classify.sv
module ctl_classify
    import ctl_pkg::*;
#(
    parameter int HAS_MUL = 0,
    parameter int HAS_DIV = 0
) (
    input  logic [OPW-1:0] opcode,
    output iclass_e        iclass
);
    localparam logic MUL_OK = (HAS_MUL != 0);
    localparam logic DIV_OK = (HAS_DIV != 0);

    logic [FNW-1:0] fn;
    logic           fn_legal;

    assign fn = opcode[FNW-1:0];

    always_comb begin
        unique case (fn)
            4'd0, 4'd1, 4'd4, 4'd5, 4'd6,
            4'd8, 4'd9, 4'd10,
            4'd12, 4'd13, 4'd14: fn_legal = 1'b1;
            4'd2:                fn_legal = MUL_OK;
            4'd3:                fn_legal = DIV_OK;
            default:             fn_legal = 1'b0;
        endcase
    end

    always_comb begin
        iclass = CL_ILL;
        unique case (opcode[OPW-1:OPW-2])
            2'b10: iclass = fn_legal ? CL_OP  : CL_ILL;
            2'b11: iclass = fn_legal ? CL_OPC : CL_ILL;
            2'b01: begin
                unique case (opcode)
                    OPC_LD:  iclass = CL_LD;
                    OPC_ST:  iclass = CL_ST;
                    OPC_LDR: iclass = CL_LDR;
                    OPC_JMP: iclass = CL_JMP;
                    OPC_BEQ: iclass = CL_BEQ;
                    OPC_BNE: iclass = CL_BNE;
                    default: iclass = CL_ILL;
                endcase
            end
            default: iclass = CL_ILL;
        endcase
    end
endmodule

// File: rtl/ctl_operand.sv
module ctl_operand
    import ctl_pkg::*;
(
    input  iclass_e        iclass,
    input  logic [FNW-1:0] fn,
    output logic [FNW-1:0] alu_fn,
    output logic           b_lit,
    output logic           rc_to_rb,
    output logic           pc_rel
);
    always_comb begin
        alu_fn   = FN_ADD;
        b_lit    = 1'b0;
        rc_to_rb = 1'b0;
        pc_rel   = 1'b0;
        unique case (iclass)
            CL_OP:  alu_fn = fn;
            CL_OPC: begin
                alu_fn = fn;
                b_lit  = 1'b1;
            end
            CL_LD:  b_lit = 1'b1;
            CL_ST: begin
                b_lit    = 1'b1;
                rc_to_rb = 1'b1;
            end
            CL_LDR: pc_rel = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/ctl_flow.sv
module ctl_flow
    import ctl_pkg::*;
(
    input  iclass_e iclass,
    input  logic    ra_zero,
    input  logic    irq,
    output pcsel_e  pc_sel,
    output logic    trap
);
    always_comb begin
        trap   = 1'b0;
        pc_sel = PC_SEQ;
        if (irq) begin
            trap   = 1'b1;
            pc_sel = PC_IRQ;
        end else begin
            unique case (iclass)
                CL_JMP: pc_sel = PC_REG;
                CL_BEQ: pc_sel = ra_zero ? PC_BR : PC_SEQ;
                CL_BNE: pc_sel = ra_zero ? PC_SEQ : PC_BR;
                CL_ILL: begin
                    trap   = 1'b1;
                    pc_sel = PC_ILLOP;
                end
                default: pc_sel = PC_SEQ;
            endcase
        end
    end
endmodule

// File: rtl/ctl_decode.sv
module ctl_decode
    import ctl_pkg::*;
#(
    parameter int HAS_MUL = 0,
    parameter int HAS_DIV = 0
) (
    input  logic [5:0] opcode,
    input  logic       ra_zero,
    input  logic       irq,
    output logic [3:0] alu_fn,
    output logic       b_lit,
    output logic       rc_to_rb,
    output logic       pc_rel,
    output logic [1:0] wd_sel,
    output logic       wa_xp,
    output logic       reg_we,
    output logic       mem_re,
    output logic       mem_we,
    output logic [2:0] pc_sel
);
    iclass_e        iclass;
    pcsel_e         pc_sel_e;
    logic           trap;
    logic [FNW-1:0] op_fn;
    logic           op_blit;
    logic           op_rcrb;
    logic           op_pcrel;
    wdsel_e         wd_e;

    ctl_classify #(.HAS_MUL(HAS_MUL), .HAS_DIV(HAS_DIV)) u_cls (
        .opcode (opcode),
        .iclass (iclass)
    );

    ctl_operand u_opd (
        .iclass   (iclass),
        .fn       (opcode[FNW-1:0]),
        .alu_fn   (op_fn),
        .b_lit    (op_blit),
        .rc_to_rb (op_rcrb),
        .pc_rel   (op_pcrel)
    );

    ctl_flow u_flow (
        .iclass  (iclass),
        .ra_zero (ra_zero),
        .irq     (irq),
        .pc_sel  (pc_sel_e),
        .trap    (trap)
    );

    // Write-back and memory side: a trap replaces the instruction with a forced call.
    always_comb begin
        wd_e   = WD_PC4;
        wa_xp  = 1'b0;
        reg_we = 1'b0;
        mem_re = 1'b0;
        mem_we = 1'b0;
        if (trap) begin
            wa_xp  = 1'b1;
            reg_we = 1'b1;
        end else begin
            unique case (iclass)
                CL_OP, CL_OPC: begin
                    wd_e   = WD_ALU;
                    reg_we = 1'b1;
                end
                CL_LD, CL_LDR: begin
                    wd_e   = WD_MEM;
                    reg_we = 1'b1;
                    mem_re = 1'b1;
                end
                CL_ST: mem_we = 1'b1;
                CL_JMP, CL_BEQ, CL_BNE: reg_we = 1'b1;
                default: ;
            endcase
        end
    end

    assign alu_fn   = trap ? FNW'(FN_ADD) : op_fn;
    assign b_lit    = op_blit  & ~trap;
    assign rc_to_rb = op_rcrb  & ~trap;
    assign pc_rel   = op_pcrel & ~trap;
    assign wd_sel   = wd_e;
    assign pc_sel   = pc_sel_e;

    always_comb begin
        if (!$isunknown({opcode, ra_zero, irq})) begin
            assert_trap_quiet_R9: assert (!(pc_sel >= 3'd3) ||
                (mem_we == 1'b0 && mem_re == 1'b0 && wa_xp && reg_we && wd_sel == 2'd0))
                else $error("trap cycle left memory or write-back active");
            assert_irq_wins_R10: assert (!irq || pc_sel == 3'd4)
                else $error("interrupt did not select its vector");
            assert_mem_excl_R5: assert ($onehot0({mem_we, mem_re, rc_to_rb & ~mem_we}))
                else $error("memory read and write together");
            assert_mem_wd_R4: assert (!(wd_sel == 2'd2) || mem_re)
                else $error("memory write-back without read");
            assert_store_nowb_R5: assert (!mem_we || (!reg_we && rc_to_rb && b_lit))
                else $error("store steering inconsistent");
            assert_pcrel_only_R11: assert (!pc_rel || (mem_re && !b_lit))
                else $error("pc-relative address outside its load");
        end
    end
endmodule

// File: tb/sim_ctl_decode.sv
module sim_ctl_decode;
    localparam int HAS_MUL = 1;
    localparam int HAS_DIV = 0;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [5:0] opcode  = 6'd0;
    logic       ra_zero = 1'b0;
    logic       irq     = 1'b0;
    logic [3:0] alu_fn;
    logic       b_lit, rc_to_rb, pc_rel, wa_xp, reg_we, mem_re, mem_we;
    logic [1:0] wd_sel;
    logic [2:0] pc_sel;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    ctl_decode #(.HAS_MUL(HAS_MUL), .HAS_DIV(HAS_DIV)) u0 (
        .opcode(opcode), .ra_zero(ra_zero), .irq(irq),
        .alu_fn(alu_fn), .b_lit(b_lit), .rc_to_rb(rc_to_rb), .pc_rel(pc_rel),
        .wd_sel(wd_sel), .wa_xp(wa_xp), .reg_we(reg_we), .mem_re(mem_re),
        .mem_we(mem_we), .pc_sel(pc_sel)
    );

    // Packing: {alu_fn, b_lit, rc_to_rb, pc_rel, wd_sel, wa_xp, reg_we, mem_re, mem_we, pc_sel}
    function automatic logic [15:0] pack(input logic [3:0] f, input logic bl, input logic rr,
                                          input logic pr, input logic [1:0] wd, input logic xp,
                                          input logic we, input logic re, input logic mw,
                                          input logic [2:0] ps);
        return {f, bl, rr, pr, wd, xp, we, re, mw, ps};
    endfunction

    function automatic bit fn_ok(input logic [3:0] f);
        case (f)
            4'd0, 4'd1, 4'd4, 4'd5, 4'd6, 4'd8, 4'd9, 4'd10, 4'd12, 4'd13, 4'd14: return 1;
            4'd2: return HAS_MUL != 0;
            4'd3: return HAS_DIV != 0;
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(input logic [5:0] op, input logic rz, input logic iq);
        if (iq) return "R10";
        if (op[5:4] == 2'b10 && fn_ok(op[3:0])) return "R1";
        if (op[5:4] == 2'b11 && fn_ok(op[3:0])) return "R2";
        case (op)
            6'h18: return "R4";
            6'h19: return "R5";
            6'h1F: return "R6";
            6'h1B: return "R7";
            6'h1D, 6'h1E: return "R8";
            default: return op[5] ? "R3" : "R9";
        endcase
    endfunction

    function automatic logic [15:0] expect_of(input logic [5:0] op, input logic rz, input logic iq);
        if (iq) return pack(4'd0, 0, 0, 0, 2'd0, 1, 1, 0, 0, 3'd4);          // R10
        if (op[5:4] == 2'b10 && fn_ok(op[3:0]))
            return pack(op[3:0], 0, 0, 0, 2'd1, 0, 1, 0, 0, 3'd0);         // R1
        if (op[5:4] == 2'b11 && fn_ok(op[3:0]))
            return pack(op[3:0], 1, 0, 0, 2'd1, 0, 1, 0, 0, 3'd0);         // R2
        case (op)
            6'h18: return pack(4'd0, 1, 0, 0, 2'd2, 0, 1, 1, 0, 3'd0);     // R4
            6'h19: return pack(4'd0, 1, 1, 0, 2'd0, 0, 0, 0, 1, 3'd0);     // R5
            6'h1F: return pack(4'd0, 0, 0, 1, 2'd2, 0, 1, 1, 0, 3'd0);     // R6
            6'h1B: return pack(4'd0, 0, 0, 0, 2'd0, 0, 1, 0, 0, 3'd2);     // R7
            6'h1D: return pack(4'd0, 0, 0, 0, 2'd0, 0, 1, 0, 0, rz ? 3'd1 : 3'd0); // R8
            6'h1E: return pack(4'd0, 0, 0, 0, 2'd0, 0, 1, 0, 0, rz ? 3'd0 : 3'd1); // R8
            default: return pack(4'd0, 0, 0, 0, 2'd0, 1, 1, 0, 0, 3'd3);   // R9, R3, R11
        endcase
    endfunction

    task automatic apply(input logic [5:0] op, input logic rz, input logic iq);
        logic [15:0] got, exp;
        @(negedge clk);
        opcode = op; ra_zero = rz; irq = iq;
        @(posedge clk);
        #1;
        got = pack(alu_fn, b_lit, rc_to_rb, pc_rel, wd_sel, wa_xp, reg_we, mem_re, mem_we, pc_sel);
        exp = expect_of(op, rz, iq);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s op=%h rz=%0b irq=%0b actual=%h expected=%h",
                     req_of(op, rz, iq), op, rz, iq, got, exp);
        end
    endtask

    initial begin
        // Reset-state style check: opcode 0 with no interrupt traps as illegal (R9, R11)
        apply(6'h00, 1'b0, 1'b0);
        // Directed corners
        apply(6'h22, 1'b0, 1'b0);  // R3 MUL legal, register form
        apply(6'h32, 1'b1, 1'b0);  // R3 MUL legal, constant form
        apply(6'h23, 1'b0, 1'b0);  // R3 DIV illegal here
        apply(6'h37, 1'b0, 1'b0);  // R3 code 7 illegal
        apply(6'h2F, 1'b0, 1'b0);  // R3 code 15 illegal
        apply(6'h1D, 1'b1, 1'b0);  // R8 taken
        apply(6'h1E, 1'b1, 1'b0);  // R8 not taken
        apply(6'h19, 1'b0, 1'b1);  // R10 interrupt beats store
        apply(6'h3F, 1'b0, 1'b1);  // R10 interrupt beats illegal
        // Exhaustive sweep
        for (int o = 0; o < 64; o++)
            for (int c = 0; c < 4; c++)
                apply(6'(o), c[0], c[1]);
        // Seeded random
        void'($urandom(32'd4242));
        for (int k = 0; k < 2000; k++) begin
            logic [5:0] ro;
            ro = 6'($urandom);
            if (($urandom % 3) == 0) ro[5] = 1'b1;
            apply(ro, 1'($urandom), ($urandom % 8) == 0);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule